// File: doc/BRIEF.md
# GPIO Port Configuration Register Bank

This block holds the configuration registers for a set of 32-bit GPIO ports. Each register holds one bit per pin, and every register bit leaves the block on a flat output bus that drives the pin logic directly. Software reaches the registers over a simple single-cycle peripheral bus. The bus has a select strobe, a write flag, a byte address and 32-bit write and read data.

Each port owns a window of 0x200 bytes. The port number sits in the address bits from bit 9 upward, and the register slot sits in bits 8..4. Each register therefore takes a 16-byte slot. Within a slot, bits 3..2 choose how a write is applied:
- a plain write of the full value;
- an alias that sets the bits written as one;
- an alias that clears the bits written as one;
- an alias that inverts the bits written as one.

With the three aliases, software can change a single pin without a read-modify-write sequence. Pin n of the chip maps to port n/32 (rounded down) and to bit n mod 32 of that port's registers. Reads return the addressed register through any of its four addresses. Holes in the map read as zero and ignore writes.

Top module: `gpio_bank`

## Requirements
- R1: While `rst` is high, every register bit on `cfg_out` and every bit of `bus_rdata` is zero from the following clock edge on.
- R2: A write (`bus_sel`=1, `bus_wr`=1) to an implemented register at kind code 0 (`bus_addr[3:2]`=0, offset +0x0) loads `bus_wdata` in full, and the new value shows on `cfg_out` after that clock edge.
- R3: A write at kind code 1 (offset +0x4) sets to one each register bit whose `bus_wdata` bit is one and leaves the other bits unchanged.
- R4: A write at kind code 2 (offset +0x8) clears to zero each register bit whose `bus_wdata` bit is one and leaves the other bits unchanged.
- R5: A write at kind code 3 (offset +0xC) inverts each register bit whose `bus_wdata` bit is one and leaves the other bits unchanged.
- R6: A read (`bus_sel`=1, `bus_wr`=0) of an implemented register through any of the four kind codes places the register's current value on `bus_rdata` after the clock edge. `bus_rdata` then holds that value until the next read.
- R7: The port index is `bus_addr[ADDR_W-1:9]` (stride 0x200), and the register slot is `bus_addr[8:4]` (stride 0x10). A write changes only the register it addresses.
- R8: An access to a port index of `NUM_PORTS` or above, or to a slot of `REG_COUNT` or above, returns zero on a read and changes no register on a write.
- R9: Bit b of register r of port p drives `cfg_out[(p*REG_COUNT + r)*32 + b]`, so global pin n is bit n mod 32 of port n/32.
- R10: In a cycle with `bus_sel` low, neither `cfg_out` nor `bus_rdata` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address: port, register slot, access kind |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Registered read data |
| cfg_out | output | NUM_PORTS*REG_COUNT*32 | All register bits, port-major then register |

## Verification
The assertions assume the following about the bus inputs:
- `bus_sel`, `bus_wr` and `bus_addr` are known at every clock edge.
- Each select lasts exactly one access.
- Address bits 1..0 carry no meaning.

The stimulus meets these conditions by building every address from port, slot and kind fields, with the low two bits held at zero. It drives each access for one cycle between falling edges and drops the select in between. Random port and slot values run one past the implemented range, so the holes in the map are reached alongside the four access kinds.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int WORD_W   = 32;
    localparam int KIND_LSB = 2;
    localparam int SLOT_LSB = 4;
    localparam int SLOT_W   = 5;
    localparam int PORT_LSB = SLOT_LSB + SLOT_W;

    typedef enum logic [1:0] {
        ACC_DIRECT = 2'd0,
        ACC_SET    = 2'd1,
        ACC_CLEAR  = 2'd2,
        ACC_TOGGLE = 2'd3
    } acc_kind_t;

    function automatic logic [WORD_W-1:0] apply_access(
        input acc_kind_t          kind,
        input logic [WORD_W-1:0]  cur,
        input logic [WORD_W-1:0]  data
    );
        logic [WORD_W-1:0] nxt;
        unique case (kind)
            ACC_DIRECT: nxt = data;
            ACC_SET:    nxt = cur | data;
            ACC_CLEAR:  nxt = cur & ~data;
            ACC_TOGGLE: nxt = cur ^ data;
            default:    nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_PORTS = 4,
    parameter int REG_COUNT = 4,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int PF_W     = ADDR_W - PORT_LSB
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [PORT_W-1:0] port_idx,
    output logic [SLOT_W-1:0] slot_idx,
    output acc_kind_t         kind,
    output logic              hit
);

    logic [PF_W-1:0] port_field;
    logic            unused_low;

    assign unused_low = ^addr[KIND_LSB-1:0];
    assign port_field = addr[ADDR_W-1:PORT_LSB];
    assign slot_idx   = addr[PORT_LSB-1:SLOT_LSB];
    assign kind       = acc_kind_t'(addr[SLOT_LSB-1:KIND_LSB]);
    assign port_idx   = port_field[PORT_W-1:0];

    always_comb begin
        hit = (int'(port_field) < NUM_PORTS) && (int'(slot_idx) < REG_COUNT);
    end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_bank_pkg::*;
#(
    parameter int REG_COUNT = 4,
    localparam int FLAT_W   = REG_COUNT * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] slot_idx,
    input  acc_kind_t         kind,
    input  logic [WORD_W-1:0] wdata,
    output logic [FLAT_W-1:0] regs_flat
);

    for (genvar r = 0; r < REG_COUNT; r++) begin : g_reg
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && (slot_idx == SLOT_W'(r))) begin
                q <= apply_access(kind, q, wdata);
            end
        end
        assign regs_flat[r*WORD_W +: WORD_W] = q;
    end

endmodule

// File: rtl/gpio_read_path.sv
module gpio_read_path
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int REG_COUNT = 4,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int TOTAL_W  = NUM_PORTS * REG_COUNT * WORD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic               hit,
    input  logic [PORT_W-1:0]  port_idx,
    input  logic [SLOT_W-1:0]  slot_idx,
    input  logic [TOTAL_W-1:0] all_regs,
    output logic [WORD_W-1:0]  rdata
);

    logic [WORD_W-1:0] sel_word;

    always_comb begin
        sel_word = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            for (int r = 0; r < REG_COUNT; r++) begin
                if (hit && (int'(port_idx) == p) && (int'(slot_idx) == r)) begin
                    sel_word = all_regs[(p*REG_COUNT + r)*WORD_W +: WORD_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= sel_word;
        end
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_PORTS = 4,
    parameter int REG_COUNT = 4,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int GROUP_W  = REG_COUNT * WORD_W,
    localparam int TOTAL_W  = NUM_PORTS * GROUP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic [TOTAL_W-1:0] cfg_out
);

    logic [PORT_W-1:0] port_idx;
    logic [SLOT_W-1:0] slot_idx;
    acc_kind_t         kind;
    logic              hit;
    logic              wr_any;
    logic              rd_any;

    assign wr_any = bus_sel && bus_wr && hit;
    assign rd_any = bus_sel && !bus_wr;

    gpio_addr_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_PORTS (NUM_PORTS),
        .REG_COUNT (REG_COUNT)
    ) u_dec (
        .addr     (bus_addr),
        .port_idx (port_idx),
        .slot_idx (slot_idx),
        .kind     (kind),
        .hit      (hit)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic port_wr;
        assign port_wr = wr_any && (port_idx == PORT_W'(p));
        gpio_port_regs #(
            .REG_COUNT (REG_COUNT)
        ) u_regs (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (port_wr),
            .slot_idx  (slot_idx),
            .kind      (kind),
            .wdata     (bus_wdata),
            .regs_flat (cfg_out[p*GROUP_W +: GROUP_W])
        );
    end

    gpio_read_path #(
        .NUM_PORTS (NUM_PORTS),
        .REG_COUNT (REG_COUNT)
    ) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_any),
        .hit      (hit),
        .port_idx (port_idx),
        .slot_idx (slot_idx),
        .all_regs (cfg_out),
        .rdata    (bus_rdata)
    );

endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker #(
    parameter int ADDR_W    = 16,
    parameter int NUM_PORTS = 4,
    parameter int REG_COUNT = 4,
    localparam int TOTAL_W  = NUM_PORTS * REG_COUNT * 32
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic [TOTAL_W-1:0] cfg_out
);

    function automatic logic in_map(input logic [ADDR_W-1:0] a);
        return (int'(a[ADDR_W-1:9]) < NUM_PORTS) && (int'(a[8:4]) < REG_COUNT);
    endfunction

    function automatic logic [31:0] pick(input logic [TOTAL_W-1:0] v,
                                         input logic [ADDR_W-1:0] a);
        logic [31:0] w;
        w = '0;
        for (int p = 0; p < NUM_PORTS; p++)
            for (int r = 0; r < REG_COUNT; r++)
                if (in_map(a) && int'(a[ADDR_W-1:9]) == p && int'(a[8:4]) == r)
                    w = v[(p*REG_COUNT + r)*32 +: 32];
        return w;
    endfunction

    logic wr_hit;
    assign wr_hit = bus_sel && bus_wr && in_map(bus_addr);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (cfg_out == '0) && (bus_rdata == '0));

    a_r2_direct_load: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && bus_addr[3:2] == 2'd0)
        |=> pick(cfg_out, $past(bus_addr)) == $past(bus_wdata));

    a_r3_set_bits: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && bus_addr[3:2] == 2'd1)
        |=> pick(cfg_out, $past(bus_addr)) ==
            ($past(pick(cfg_out, bus_addr)) | $past(bus_wdata)));

    a_r4_clear_bits: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && bus_addr[3:2] == 2'd2)
        |=> pick(cfg_out, $past(bus_addr)) ==
            ($past(pick(cfg_out, bus_addr)) & ~$past(bus_wdata)));

    a_r5_toggle_bits: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && bus_addr[3:2] == 2'd3)
        |=> pick(cfg_out, $past(bus_addr)) ==
            ($past(pick(cfg_out, bus_addr)) ^ $past(bus_wdata)));

    a_r6_read_value: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && in_map(bus_addr))
        |=> bus_rdata == $past(pick(cfg_out, bus_addr)));

    a_r8_hole_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && !in_map(bus_addr)) |=> bus_rdata == '0);

    a_r8_hole_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && !in_map(bus_addr)) |=> $stable(cfg_out));

    a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |=> $stable(cfg_out) && $stable(bus_rdata));

endmodule

bind gpio_bank gpio_bank_checker #(
    .ADDR_W    (ADDR_W),
    .NUM_PORTS (NUM_PORTS),
    .REG_COUNT (REG_COUNT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg_out   (cfg_out)
);

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;

    localparam int ADDR_W    = 16;
    localparam int NUM_PORTS = 4;
    localparam int REG_COUNT = 4;
    localparam int TOTAL_W   = NUM_PORTS * REG_COUNT * 32;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               bus_sel = 1'b0;
    logic               bus_wr = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic [TOTAL_W-1:0] cfg_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] mdl [NUM_PORTS][REG_COUNT];
    logic [31:0] last_rd = '0;

    always #5 clk = ~clk;

    gpio_bank #(
        .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .REG_COUNT(REG_COUNT)
    ) uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cfg_out(cfg_out)
    );

    function automatic logic [ADDR_W-1:0] mk_addr(input int port, input int slot,
                                                  input int kind);
        return ADDR_W'(port * 32'h200 + slot * 32'h10 + kind * 4);
    endfunction

    function automatic logic [31:0] model_word(input int port, input int slot);
        if (port >= NUM_PORTS || slot >= REG_COUNT) return 32'h0;
        return mdl[port][slot];
    endfunction

    function automatic logic [TOTAL_W-1:0] model_flat();
        logic [TOTAL_W-1:0] v;
        for (int p = 0; p < NUM_PORTS; p++)
            for (int r = 0; r < REG_COUNT; r++)
                v[(p*REG_COUNT + r)*32 +: 32] = mdl[p][r];
        return v;
    endfunction

    function automatic logic [31:0] next_word(input int kind, input logic [31:0] cur,
                                              input logic [31:0] d);
        logic [31:0] n;
        n = cur;
        for (int b = 0; b < 32; b++) begin
            if (kind == 0) n[b] = d[b];
            else if (d[b]) begin
                if (kind == 1)      n[b] = 1'b1;
                else if (kind == 2) n[b] = 1'b0;
                else                n[b] = ~cur[b];
            end
        end
        return n;
    endfunction

    task automatic check_flat(input string tag);
        checks++;
        if (cfg_out !== model_flat()) begin
            errors++;
            $display("FAIL %s cfg_out=%h expected=%h", tag, cfg_out, model_flat());
        end
    endtask

    task automatic check_rdata(input string tag, input logic [31:0] exp);
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s rdata=%h expected=%h", tag, bus_rdata, exp);
        end
    endtask

    task automatic do_write(input int port, input int slot, input int kind,
                            input logic [31:0] d, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1;
        bus_addr = mk_addr(port, slot, kind); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        if (port < NUM_PORTS && slot < REG_COUNT)
            mdl[port][slot] = next_word(kind, mdl[port][slot], d);
        check_flat(tag);
        check_rdata({tag, " rdata held"}, last_rd);
    endtask

    task automatic do_read(input int port, input int slot, input int kind,
                           input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0;
        bus_addr = mk_addr(port, slot, kind);
        bus_wdata = $urandom;
        @(negedge clk);
        bus_sel = 1'b0;
        last_rd = model_word(port, slot);
        check_rdata(tag, last_rd);
        check_flat({tag, " no change"});
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int p = 0; p < NUM_PORTS; p++)
            for (int r = 0; r < REG_COUNT; r++) mdl[p][r] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_flat("R1 reset cfg_out");
        check_rdata("R1 reset rdata", 32'h0);

        do_write(0, 0, 0, 32'hA5A5_F00F, "R2 direct write");
        do_write(0, 0, 1, 32'h0000_0FF0, "R3 set alias");
        do_write(0, 0, 2, 32'hA000_0001, "R4 clear alias");
        do_write(0, 0, 3, 32'hFFFF_0000, "R5 toggle alias");
        for (int k = 0; k < 4; k++) do_read(0, 0, k, "R6 read via alias");
        do_write(3, 3, 0, 32'h1234_5678, "R7 last port last slot");
        do_write(2, 1, 0, 32'h8765_4321, "R7 port stride");
        do_read(3, 3, 0, "R7 readback far register");
        do_write(NUM_PORTS, 0, 0, 32'hFFFF_FFFF, "R8 write to missing port");
        do_write(1, 31, 1, 32'hFFFF_FFFF, "R8 write to missing slot");
        do_write(100, 2, 3, 32'hFFFF_FFFF, "R8 write to far port");
        do_read(NUM_PORTS, 0, 0, "R8 read missing port");
        do_read(0, REG_COUNT, 2, "R8 read missing slot");

        do_write(1, 1, 1, 32'h1 << (36 % 32), "R9 pin 36 set");
        checks++;
        if (cfg_out[(1*REG_COUNT + 1)*32 + 4] !== 1'b1) begin
            errors++;
            $display("FAIL R9 pin 36 bit=%b expected=1",
                     cfg_out[(1*REG_COUNT + 1)*32 + 4]);
        end

        repeat (4) @(negedge clk);
        check_flat("R10 idle cfg_out");
        check_rdata("R10 idle rdata", last_rd);

        for (int i = 0; i < 600; i++) begin
            int port, slot, kind;
            port = $urandom_range(0, NUM_PORTS);
            slot = $urandom_range(0, REG_COUNT);
            kind = $urandom_range(0, 3);
            if ($urandom_range(0, 2) == 0) begin
                do_read(port, slot, kind, "R6 random read");
            end else begin
                case (kind)
                    0: do_write(port, slot, kind, $urandom, "R2 random direct");
                    1: do_write(port, slot, kind, $urandom, "R3 random set");
                    2: do_write(port, slot, kind, $urandom, "R4 random clear");
                    default: do_write(port, slot, kind, $urandom, "R5 random toggle");
                endcase
            end
        end

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++)
            for (int r = 0; r < REG_COUNT; r++) mdl[p][r] = '0;
        check_flat("R1 second reset cfg_out");
        check_rdata("R1 second reset rdata", 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule